// File: doc/BRIEF.md
# Register-Pair Double-Add Sequencer

This block models how a processor with an 8-bit internal datapath executes a one-byte instruction that adds a 16-bit register pair into the HL pair. It holds the BC, DE and HL pairs and an 8-bit flag register. A start strobe launches the instruction with an opcode byte. The block then steps through an opcode-fetch machine cycle of four T-states, followed by two machine cycles of three T-states each. No bus activity happens in those last two cycles. The 16-bit sum is formed by one 8-bit adder used twice. The first execution cycle adds the low bytes, and the second adds the high bytes with the stored carry.

Preload ports set the registers while the sequencer is idle, so a surrounding model or a testbench can set up operands. The machine-cycle and T-state indicators and the ALE and RD strobes let a bus-level observer follow the timing. A one-cycle done pulse marks the point where the result is visible.

Top module: `dad_seq`

## Requirements
- R1: Opcode 0x09 adds BC, 0x19 adds DE and 0x29 adds HL into HL. The new HL is (HL + pair) mod 2^16.
- R2: Executing an add leaves the BC and DE outputs unchanged. This includes the pair that was selected as the addend.
- R3: Flag bit 0 (carry) receives the carry out of bit 15 of the sum. Flag bits 7..1 keep their previous values.
- R4: Machine-cycle and T-state encoding and sequence:
  - While idle, mcycle=0 and tstate=0.
  - A start accepted while idle gives mcycle=1, tstate=1 in the next clock.
  - mcycle 1 runs T-states 1..4, mcycle 2 runs 1..3 and mcycle 3 runs 1..3, one T-state per clock.
  - The block then returns to idle.
  - A valid instruction therefore spans 10 clocks.
- R5: ALE is high only in mcycle 1 T-state 1, and it is followed directly by RD. RD is high only in mcycle 1 T-states 2 and 3. Both strobes stay low in mcycles 2 and 3 and while idle.
- R6: The low-byte add completes at the end of mcycle 2. During mcycle 3, the low byte of HL already shows the new value while the high byte still shows the old one.
- R7: done is high for exactly one clock, immediately after mcycle 3 T-state 3. In that same clock, the final HL and carry are visible and mcycle=0.
- R8: For opcode 0x29, both operands are the HL value from before the instruction, so the result is HL doubled. The carry is bit 15 of the old HL.
- R9: Any other opcode runs only the 4-T-state fetch cycle and then returns to idle. It raises no done and changes no register or flag.
- R10: While the sequencer is busy (mcycle not 0), start and the preload port are ignored.
- R11: When idle, load_en writes load_data into the target chosen by load_sel, visible from the next clock:
  - load_sel 0 writes BC.
  - load_sel 1 writes DE.
  - load_sel 2 writes HL.
  - load_sel 3 writes the flags from load_data[7:0].
  - All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an instruction (accepted while idle) |
| opcode | input | 8 | Instruction byte sampled with start |
| load_en | input | 1 | Preload write enable (idle only) |
| load_sel | input | 2 | Preload target: 0 BC, 1 DE, 2 HL, 3 flags |
| load_data | input | 16 | Preload value |
| hl | output | 16 | HL pair |
| bc | output | 16 | BC pair |
| de | output | 16 | DE pair |
| flags | output | 8 | Flag register, carry in bit 0 |
| mcycle | output | 2 | Machine cycle, 0 when idle |
| tstate | output | 3 | T-state within the machine cycle, 0 when idle |
| ale | output | 1 | Address latch strobe |
| rd | output | 1 | Read strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded assertions check the following on every cycle:
- ALE handing over directly to RD.
- The fetch T-state counting up one per clock.
- The move from the low-byte cycle into the high-byte cycle.
- The high byte of HL holding still during the low-byte cycle.
- BC, DE and the upper flag bits staying constant while busy.
- done lasting one clock.
- An unknown opcode dropping back to idle with HL and flags untouched.

The arithmetic results need the bench's scenarios and its per-clock reference model. These include the sums, the carry out of bit 15, the doubling of HL, and the refusal of start and preload while busy. The same applies to the exact clock at which each half of HL changes.

// File: rtl/dad_pkg.sv
package dad_pkg;
    localparam int DW      = 8;
    localparam int FETCH_T = 4;
    localparam int IDLE_T  = 3;
    localparam int TW      = 3;
    localparam int CY_BIT  = 0;

    localparam logic [DW-1:0] OP_ADD_BC = 8'h09;
    localparam logic [DW-1:0] OP_ADD_DE = 8'h19;
    localparam logic [DW-1:0] OP_ADD_HL = 8'h29;

    typedef enum logic [1:0] {PAIR_BC, PAIR_DE, PAIR_HL, PAIR_NONE} pair_e;
    typedef enum logic [1:0] {MC_IDLE, MC_FETCH, MC_EXEC_LO, MC_EXEC_HI} mcyc_e;
endpackage

// File: rtl/dad_alu8.sv
module dad_alu8 #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end
endmodule

// File: rtl/dad_timing.sv
module dad_timing
    import dad_pkg::*;
#(
    parameter int FT = FETCH_T,
    parameter int IT = IDLE_T
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          abort,
    output mcyc_e         mc,
    output logic [TW-1:0] ts,
    output logic          last_t,
    output logic          ale,
    output logic          rd
);
    typedef struct packed {
        mcyc_e         mc;
        logic [TW-1:0] t;
    } tstate_s;

    tstate_s       s_q, s_d;
    logic [TW-1:0] lim;

    always_comb begin
        lim    = (s_q.mc == MC_FETCH) ? TW'(FT) : TW'(IT);
        last_t = (s_q.mc != MC_IDLE) && (s_q.t == lim);
        s_d    = s_q;
        if (s_q.mc == MC_IDLE) begin
            if (go) begin
                s_d.mc = MC_FETCH;
                s_d.t  = TW'(1);
            end
        end else if (last_t) begin
            if (s_q.mc == MC_EXEC_HI || (s_q.mc == MC_FETCH && abort)) begin
                s_d.mc = MC_IDLE;
                s_d.t  = '0;
            end else begin
                s_d.mc = mcyc_e'(s_q.mc + 2'd1);
                s_d.t  = TW'(1);
            end
        end else begin
            s_d.t = s_q.t + TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mc <= MC_IDLE;
            s_q.t  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mc  = s_q.mc;
    assign ts  = s_q.t;
    assign ale = (s_q.mc == MC_FETCH) && (s_q.t == TW'(1));
    assign rd  = (s_q.mc == MC_FETCH) && (s_q.t == TW'(2) || s_q.t == TW'(3));

    // R5
    ale_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (rd && !ale));
    // R4
    fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mc == MC_FETCH && s_q.t < TW'(FT)) |=>
        (s_q.mc == MC_FETCH && s_q.t == $past(s_q.t) + TW'(1)));
    // R4
    lo_to_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_t && s_q.mc == MC_EXEC_LO) |=> (s_q.mc == MC_EXEC_HI && s_q.t == TW'(1)));
endmodule

// File: rtl/dad_seq.sv
module dad_seq
    import dad_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic          load_en,
    input  logic [1:0]    load_sel,
    input  logic [15:0]   load_data,
    output logic [15:0]   hl,
    output logic [15:0]   bc,
    output logic [15:0]   de,
    output logic [7:0]    flags,
    output logic [1:0]    mcycle,
    output logic [2:0]    tstate,
    output logic          ale,
    output logic          rd,
    output logic          done
);
    typedef struct packed {
        logic [DW-1:0] b, c, d, e, h, l, f;
        pair_e         sel;
        logic          cyt;
        logic          done;
    } core_s;

    core_s         q, n;
    mcyc_e         mc;
    logic [TW-1:0] ts;
    logic          last_t, go, abort;
    logic [DW-1:0] p_lo, p_hi, alu_a, alu_b, alu_s;
    logic          alu_ci, alu_co;

    dad_timing #(.FT(FETCH_T), .IT(IDLE_T)) u_tim (
        .clk(clk), .rst_n(rst_n), .go(go), .abort(abort),
        .mc(mc), .ts(ts), .last_t(last_t), .ale(ale), .rd(rd)
    );

    dad_alu8 #(.W(DW)) u_alu (
        .a(alu_a), .b(alu_b), .cin(alu_ci), .sum(alu_s), .cout(alu_co)
    );

    assign go    = start && (mc == MC_IDLE);
    assign abort = (q.sel == PAIR_NONE);

    always_comb begin
        case (q.sel)
            PAIR_BC: begin p_lo = q.c; p_hi = q.b; end
            PAIR_DE: begin p_lo = q.e; p_hi = q.d; end
            PAIR_HL: begin p_lo = q.l; p_hi = q.h; end
            default: begin p_lo = '0;  p_hi = '0;  end
        endcase
        alu_a  = (mc == MC_EXEC_HI) ? q.h   : q.l;
        alu_b  = (mc == MC_EXEC_HI) ? p_hi  : p_lo;
        alu_ci = (mc == MC_EXEC_HI) ? q.cyt : 1'b0;

        n      = q;
        n.done = 1'b0;
        if (mc == MC_IDLE && load_en) begin
            case (load_sel)
                2'd0:    {n.b, n.c} = load_data;
                2'd1:    {n.d, n.e} = load_data;
                2'd2:    {n.h, n.l} = load_data;
                default: n.f        = load_data[DW-1:0];
            endcase
        end
        if (go) begin
            case (opcode)
                OP_ADD_BC: n.sel = PAIR_BC;
                OP_ADD_DE: n.sel = PAIR_DE;
                OP_ADD_HL: n.sel = PAIR_HL;
                default:   n.sel = PAIR_NONE;
            endcase
        end
        if (last_t && mc == MC_EXEC_LO) begin
            n.l   = alu_s;
            n.cyt = alu_co;
        end
        if (last_t && mc == MC_EXEC_HI) begin
            n.h         = alu_s;
            n.f[CY_BIT] = alu_co;
            n.done      = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.sel <= PAIR_NONE;
        end else begin
            q <= n;
        end
    end

    assign hl     = {q.h, q.l};
    assign bc     = {q.b, q.c};
    assign de     = {q.d, q.e};
    assign flags  = q.f;
    assign mcycle = mc;
    assign tstate = ts;
    assign done   = q.done;

    // R2
    pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mc != MC_IDLE) |=> ($stable(bc) && $stable(de)));
    // R3
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mc != MC_IDLE) |=> $stable(flags[7:1]));
    // R6
    high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mc == MC_EXEC_LO) |=> $stable(hl[15:8]));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mc == MC_FETCH && last_t && abort) |=>
        (mc == MC_IDLE && $stable(hl) && $stable(flags) && !done));
endmodule

// File: tb/dad_seq_test.sv
`timescale 1ns/1ps
module dad_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic        load_en = 1'b0;
    logic [1:0]  load_sel = 2'd0;
    logic [15:0] load_data = 16'h0;
    logic [15:0] hl, bc, de;
    logic [7:0]  flags;
    logic [1:0]  mcycle;
    logic [2:0]  tstate;
    logic        ale, rd, done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dad_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .load_en(load_en), .load_sel(load_sel), .load_data(load_data),
        .hl(hl), .bc(bc), .de(de), .flags(flags), .mcycle(mcycle),
        .tstate(tstate), .ale(ale), .rd(rd), .done(done)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference model: counts elapsed T-states of the instruction (0 = idle)
    int          step = 0;
    int          m_sel = 3;
    logic [15:0] m_bc = 0, m_de = 0, m_hl = 0;
    logic [7:0]  m_f = 0;
    logic        m_done = 0;
    logic [16:0] m_sum = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            step = 0; m_sel = 3; m_bc = 0; m_de = 0; m_hl = 0; m_f = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (step == 0) begin
                if (load_en) begin
                    if (load_sel == 0) m_bc = load_data;
                    else if (load_sel == 1) m_de = load_data;
                    else if (load_sel == 2) m_hl = load_data;
                    else m_f = load_data[7:0];
                end
                if (start) begin
                    step = 1;
                    m_sel = (opcode == 8'h09) ? 0 : (opcode == 8'h19) ? 1 :
                            (opcode == 8'h29) ? 2 : 3;
                end
            end else if (step == 4 && m_sel == 3) begin
                step = 0;
            end else if (step == 7) begin
                m_sum = {1'b0, m_hl} + {1'b0, (m_sel == 0) ? m_bc : (m_sel == 1) ? m_de : m_hl};
                m_hl[7:0] = m_sum[7:0];
                step = 8;
            end else if (step == 10) begin
                m_hl[15:8] = m_sum[15:8];
                m_f[0] = m_sum[16];
                m_done = 1;
                step = 0;
            end else begin
                step++;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int emc, ets;
            emc = (step == 0) ? 0 : (step <= 4) ? 1 : (step <= 7) ? 2 : 3;
            ets = (step == 0) ? 0 : (step <= 4) ? step : (step <= 7) ? step - 4 : step - 7;
            chk("R1", "hl model", hl, m_hl);
            chk("R2", "bc model", bc, m_bc);
            chk("R2", "de model", de, m_de);
            chk("R3", "flags model", flags, m_f);
            chk("R4", "mcycle model", mcycle, emc);
            chk("R4", "tstate model", tstate, ets);
            chk("R5", "ale model", ale, step == 1);
            chk("R5", "rd model", rd, step == 2 || step == 3);
            chk("R7", "done model", done, m_done);
        end
    end

    task automatic load(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        load_en = 1; load_sel = sel; load_data = val;
        @(negedge clk);
        load_en = 0;
    endtask

    task automatic run(input logic [7:0] op, output int busy);
        @(negedge clk);
        start = 1; opcode = op;
        @(negedge clk);
        start = 0;
        busy = 0;
        while (mcycle != 0) begin
            busy++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int busy;
        logic [15:0] s_hl, s_bc;
        logic [7:0]  s_f;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "reset hl", hl, 16'h0);
        chk("R11", "reset flags", flags, 8'h0);
        chk("R4", "reset mcycle idle", mcycle, 2'd0);

        // R1 example and R6 half-way state
        load(2'd0, 16'h4060);
        load(2'd2, 16'h4050);
        chk("R11", "bc preload", bc, 16'h4060);
        @(negedge clk);
        start = 1; opcode = 8'h09;
        @(negedge clk);
        start = 0;
        while (mcycle != 3) @(negedge clk);
        chk("R6", "low byte updated, high byte old", hl, 16'h40B0);
        while (mcycle != 0) @(negedge clk);
        chk("R7", "done with result", done, 1'b1);
        chk("R1", "bc variant sum", hl, 16'h80B0);
        chk("R3", "carry clear", flags[0], 1'b0);
        chk("R2", "bc kept", bc, 16'h4060);

        // R3 carry set, upper flag bits preserved, DE variant
        load(2'd3, 16'h00FE);
        load(2'd1, 16'hC000);
        load(2'd2, 16'h8123);
        run(8'h19, busy);
        chk("R4", "valid busy length", busy, 10);
        chk("R1", "de variant sum", hl, 16'h4123);
        chk("R3", "carry and kept bits", flags, 8'hFF);

        // R8 HL doubling with carry out
        load(2'd2, 16'h9081);
        run(8'h29, busy);
        chk("R8", "hl doubled", hl, 16'h2102);
        chk("R8", "carry from bit 15", flags[0], 1'b1);

        // R9 unknown opcode
        s_hl = hl; s_bc = bc; s_f = flags;
        run(8'h39, busy);
        chk("R9", "fetch only length", busy, 4);
        chk("R9", "hl untouched", hl, s_hl);
        chk("R9", "flags untouched", flags, s_f);
        chk("R9", "no done", done, 1'b0);

        // R10 start and preload ignored while busy
        load(2'd0, 16'h00FF);
        load(2'd2, 16'h0001);
        @(negedge clk);
        start = 1; opcode = 8'h09;
        @(negedge clk);
        load_en = 1; load_sel = 2'd0; load_data = 16'hFFFF; opcode = 8'h19;
        repeat (3) @(negedge clk);
        start = 0; load_en = 0;
        while (mcycle != 0) @(negedge clk);
        chk("R10", "bc not reloaded", bc, 16'h00FF);
        chk("R10", "sum uses original pair", hl, 16'h0100);
        chk("R3", "carry clear after low carry", flags[0], 1'b0);

        // R7 back-to-back start in the done cycle
        start = 1; opcode = 8'h09;
        @(negedge clk);
        start = 0;
        chk("R4", "restart from done cycle", mcycle, 2'd1);
        while (mcycle != 0) @(negedge clk);
        chk("R1", "second add", hl, 16'h01FF);
        @(negedge clk);
        chk("R7", "done single cycle", done, 1'b0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule